// File: doc/BRIEF.md
# Multiplexed bus cycle sequencer

This block produces the timing of one processor-style bus cycle on a shared address/data bus. It runs from a fast clock at twice the bus-clock rate. A phase bit toggles on every fast clock, so each bus T-state covers exactly two fast clocks: phase 1 (`phase_o` = 0) and phase 2 (`phase_o` = 1). A cycle walks through T1, T2 and T3, then any number of wait states TW, then T4. When no work is pending, the sequencer sits in the idle state TI.

A requester presents a 3-bit cycle status code, an address and write data, and holds them until the block acknowledges. The sequencer announces the cycle by raising the address-latch strobe and driving the status code in phase 2 of the state just before T1. It drives the address throughout T1 and drops the strobe at the middle of T1. A ready input stretches the cycle with wait states. The read data is captured at the end of the last T3/TW. A built-in latch model shows what external logic would hold after the strobe falls: the address and the status code, kept for the rest of the cycle.

The status code 3'b111 is the passive code and never starts a cycle. A code with bit 1 set and bit 0 clear is a write; every other active code is a read. `tstate_o` encodes TI=0, T1=1, T2=2, T3=3, TW=4, T4=5.

Top module: `mux_bus_seq`

## Requirements
- R1: While reset is asserted, the block shows TI (`tstate_o`=0) in phase 1 (`phase_o`=0), with `ale_o`=0, `sts_o`=3'b111, `ad_oe_o`=0, `done_o`=0 and `req_ack_o`=0.
- R2: `phase_o` toggles on every fast clock. `tstate_o` changes only on the edge that ends phase 2.
- R3: `req_ack_o` is high, and the request is taken, only in phase 1 of T4 or TI, while `req_i` is high and `req_sts_i` is not 3'b111. A request with code 3'b111 leaves the block in TI with `ale_o` low.
- R4: After acceptance, `ale_o` is high in phase 2 of the current T4/TI and in phase 1 of T1. It is low in phase 2 of T1 and for the rest of the cycle. `sts_o` carries the accepted code from that same phase-2 announcement onwards.
- R5: In both phases of T1, `ad_oe_o` is high and `ad_o` carries the request address.
- R6: The states follow the order T1, T2, T3, zero or more TW, then T4.
- R7: `ready_i` is sampled at the edge that ends phase 1 of T3 and of each TW. Low leads to another TW; high makes the next state T4.
- R8: `sts_o` holds the cycle code through phase 1 of T3, or of the last TW. It is 3'b111 from phase 2 of that state and in T4 phase 1.
- R9: For a write, `ad_oe_o` is high and `ad_o` equals the write data from T2 through T4. For a read, `ad_oe_o` is low from T2 through T4, and `rdata_o` holds the `ad_i` value sampled at the end of the last T3/TW.
- R10: `done_o` is a one-clock pulse in phase 1 of T4 and is low in every other phase.
- R11: `lat_addr_o` and `lat_sts_o` hold the address and code present while `ale_o` was high. They are valid from phase 2 of T1 and stay unchanged until the next strobe.
- R12: A request accepted in T4 goes straight to T1 without an idle state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, twice the bus-clock rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request pending |
| req_sts_i | input | 3 | Cycle status code of the request |
| req_addr_i | input | W | Request address |
| req_wdata_i | input | W | Write data |
| req_ack_o | output | 1 | Request taken this clock |
| ready_i | input | 1 | Ready; low inserts wait states |
| ad_i | input | W | Bus value driven by the target |
| ad_o | output | W | Bus value driven by the block |
| ad_oe_o | output | 1 | Output enable for `ad_o` |
| ale_o | output | 1 | Address-latch strobe |
| sts_o | output | 3 | Cycle status code, 3'b111 when passive |
| done_o | output | 1 | Cycle-complete pulse |
| rdata_o | output | W | Captured read data |
| tstate_o | output | 3 | Current T-state |
| phase_o | output | 1 | Current phase (0 = phase 1) |
| lat_addr_o | output | W | Address held by the latch model |
| lat_sts_o | output | 3 | Status code held by the latch model |

## Verification
The assertions assume that a requester keeps its request fields stable until `req_ack_o` and never changes them in the middle of a clock. They also assume that `ready_i` and `ad_i` settle before the sampling edge. The bench drives every input at the falling clock edge and drops `req_i` in the phase after acknowledge. It raises `req_i` in T2 only to show that no acknowledge appears there. The bench sweeps every active status code against zero to three wait states, and mixes idle gaps with back-to-back cycles, so the stimulus never leaves these bounds.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;
  typedef enum logic [2:0] {
    TS_IDLE = 3'd0,
    TS_T1   = 3'd1,
    TS_T2   = 3'd2,
    TS_T3   = 3'd3,
    TS_TW   = 3'd4,
    TS_T4   = 3'd5
  } tstate_e;

  localparam logic [2:0] STS_PASSIVE = 3'b111;

  function automatic logic sts_is_write(logic [2:0] s);
    return s[1] & ~s[0];
  endfunction
endpackage

// File: rtl/bus_phase_fsm.sv
module bus_phase_fsm
  import mux_bus_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  input  logic [2:0] req_sts_i,
  input  logic    ready_i,
  output tstate_e state_o,
  output logic    phase_o,
  output logic    pend_o,
  output logic    rdy_o,
  output logic    accept_o,
  output logic    load_o,
  output logic    capture_o,
  output logic    done_o
);
  tstate_e state_q;
  logic    phase_q, pend_q, rdy_q;
  logic    slot;

  assign slot      = (state_q == TS_IDLE) || (state_q == TS_T4);
  assign accept_o  = req_i && slot && !phase_q && (req_sts_i != STS_PASSIVE);
  assign load_o    = phase_q && slot && pend_q;
  assign capture_o = phase_q && rdy_q && ((state_q == TS_T3) || (state_q == TS_TW));
  assign done_o    = (state_q == TS_T4) && !phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TS_IDLE;
      phase_q <= 1'b0;
      pend_q  <= 1'b0;
      rdy_q   <= 1'b0;
    end else if (!phase_q) begin
      phase_q <= 1'b1;
      if (accept_o) pend_q <= 1'b1;
      if ((state_q == TS_T3) || (state_q == TS_TW)) rdy_q <= ready_i;
    end else begin
      phase_q <= 1'b0;
      unique case (state_q)
        TS_IDLE, TS_T4: begin
          state_q <= pend_q ? TS_T1 : TS_IDLE;
          pend_q  <= 1'b0;
        end
        TS_T1:        state_q <= TS_T2;
        TS_T2:        state_q <= TS_T3;
        TS_T3, TS_TW: begin
          state_q <= rdy_q ? TS_T4 : TS_TW;
          rdy_q   <= 1'b0;
        end
        default:      state_q <= TS_IDLE;
      endcase
    end
  end

  assign state_o = state_q;
  assign phase_o = phase_q;
  assign pend_o  = pend_q;
  assign rdy_o   = rdy_q;
endmodule

// File: rtl/bus_drv.sv
module bus_drv
  import mux_bus_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  tstate_e      state_i,
  input  logic         phase_i,
  input  logic         pend_i,
  input  logic         rdy_i,
  input  logic         accept_i,
  input  logic         load_i,
  input  logic         capture_i,
  input  logic [2:0]   req_sts_i,
  input  logic [W-1:0] req_addr_i,
  input  logic [W-1:0] req_wdata_i,
  input  logic [W-1:0] ad_i,
  output logic [W-1:0] ad_o,
  output logic         ad_oe_o,
  output logic         ale_o,
  output logic [2:0]   sts_o,
  output logic [W-1:0] rdata_o
);
  logic [2:0]   nxt_sts_q, cur_sts_q;
  logic [W-1:0] nxt_addr_q, nxt_wdata_q, cur_addr_q, cur_wdata_q, rdata_q;
  logic         cur_wr, slot, late, announce, active, data_ph;

  assign cur_wr = sts_is_write(cur_sts_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nxt_sts_q   <= STS_PASSIVE;
      nxt_addr_q  <= '0;
      nxt_wdata_q <= '0;
      cur_sts_q   <= STS_PASSIVE;
      cur_addr_q  <= '0;
      cur_wdata_q <= '0;
      rdata_q     <= '0;
    end else begin
      if (accept_i) begin
        nxt_sts_q   <= req_sts_i;
        nxt_addr_q  <= req_addr_i;
        nxt_wdata_q <= req_wdata_i;
      end
      if (load_i) begin
        cur_sts_q   <= nxt_sts_q;
        cur_addr_q  <= nxt_addr_q;
        cur_wdata_q <= nxt_wdata_q;
      end
      if (capture_i && !cur_wr) rdata_q <= ad_i;
    end
  end

  assign slot     = (state_i == TS_IDLE) || (state_i == TS_T4);
  assign late     = (state_i == TS_T3) || (state_i == TS_TW);
  assign announce = slot && phase_i && pend_i;
  // code withdrawn in phase 2 of the last T3/TW
  assign active   = (state_i == TS_T1) || (state_i == TS_T2) || (late && !(phase_i && rdy_i));
  assign data_ph  = (state_i == TS_T2) || late || (state_i == TS_T4);

  always_comb begin
    ale_o   = announce || ((state_i == TS_T1) && !phase_i);
    sts_o   = announce ? nxt_sts_q : (active ? cur_sts_q : STS_PASSIVE);
    ad_oe_o = (state_i == TS_T1) || (cur_wr && data_ph);
    if (state_i == TS_T1)        ad_o = cur_addr_q;
    else if (cur_wr && data_ph)  ad_o = cur_wdata_q;
    else                         ad_o = '0;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/bus_addr_latch.sv
module bus_addr_latch
  import mux_bus_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         ale_i,
  input  logic [W-1:0] bus_i,
  input  logic [2:0]   sts_i,
  output logic [W-1:0] addr_o,
  output logic [2:0]   sts_o
);
  // transparent while strobe high, holds from its falling edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      sts_o  <= STS_PASSIVE;
    end else if (ale_i) begin
      addr_o <= bus_i;
      sts_o  <= sts_i;
    end
  end
endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
  import mux_bus_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         req_i,
  input  logic [2:0]   req_sts_i,
  input  logic [W-1:0] req_addr_i,
  input  logic [W-1:0] req_wdata_i,
  output logic         req_ack_o,
  input  logic         ready_i,
  input  logic [W-1:0] ad_i,
  output logic [W-1:0] ad_o,
  output logic         ad_oe_o,
  output logic         ale_o,
  output logic [2:0]   sts_o,
  output logic         done_o,
  output logic [W-1:0] rdata_o,
  output logic [2:0]   tstate_o,
  output logic         phase_o,
  output logic [W-1:0] lat_addr_o,
  output logic [2:0]   lat_sts_o
);
  tstate_e      state;
  logic         phase, pend, rdy, accept, load, capture;
  logic [W-1:0] bus_val;

  bus_phase_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .req_sts_i (req_sts_i),
    .ready_i   (ready_i),
    .state_o   (state),
    .phase_o   (phase),
    .pend_o    (pend),
    .rdy_o     (rdy),
    .accept_o  (accept),
    .load_o    (load),
    .capture_o (capture),
    .done_o    (done_o)
  );

  bus_drv #(.W(W)) u_drv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .phase_i     (phase),
    .pend_i      (pend),
    .rdy_i       (rdy),
    .accept_i    (accept),
    .load_i      (load),
    .capture_i   (capture),
    .req_sts_i   (req_sts_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .ad_i        (ad_i),
    .ad_o        (ad_o),
    .ad_oe_o     (ad_oe_o),
    .ale_o       (ale_o),
    .sts_o       (sts_o),
    .rdata_o     (rdata_o)
  );

  assign bus_val = ad_oe_o ? ad_o : ad_i;

  bus_addr_latch #(.W(W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ale_i  (ale_o),
    .bus_i  (bus_val),
    .sts_i  (sts_o),
    .addr_o (lat_addr_o),
    .sts_o  (lat_sts_o)
  );

  assign req_ack_o = accept;
  assign tstate_o  = state;
  assign phase_o   = phase;
endmodule

// File: rtl/mux_bus_seq_chk.sv
module mux_bus_seq_chk #(
  parameter int W = 16
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         req_i,
  input logic [2:0]   req_sts_i,
  input logic         req_ack_o,
  input logic         ad_oe_o,
  input logic         ale_o,
  input logic [2:0]   sts_o,
  input logic         done_o,
  input logic [2:0]   tstate_o,
  input logic         phase_o,
  input logic [W-1:0] lat_addr_o
);
  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_T1   = 3'd1;
  localparam logic [2:0] S_T2   = 3'd2;
  localparam logic [2:0] S_T4   = 3'd5;

  assert_phase_toggle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o |=> !phase_o);
  assert_state_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !phase_o |=> $stable(tstate_o));
  assert_ack_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ack_o |-> (req_i && !phase_o && req_sts_i != 3'b111 &&
                   (tstate_o == S_IDLE || tstate_o == S_T4)));
  assert_ale_fall_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ale_o && tstate_o == S_T1) |=> !ale_o);
  assert_ale_window_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> ((tstate_o == S_T1 && !phase_o) ||
               ((tstate_o == S_IDLE || tstate_o == S_T4) && phase_o)));
  assert_addr_drive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tstate_o == S_T1) |-> ad_oe_o);
  assert_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tstate_o == S_T1 && phase_o) |=> (tstate_o == S_T2));
  assert_passive_t4_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tstate_o == S_T4 && !phase_o) |-> (sts_o == 3'b111));
  assert_done_slot_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (tstate_o == S_T4 && !phase_o));
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_latch_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_o && !$rose(ale_o) && tstate_o == S_T2) |=> $stable(lat_addr_o));
endmodule

bind mux_bus_seq mux_bus_seq_chk #(.W(W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .req_sts_i  (req_sts_i),
  .req_ack_o  (req_ack_o),
  .ad_oe_o    (ad_oe_o),
  .ale_o      (ale_o),
  .sts_o      (sts_o),
  .done_o     (done_o),
  .tstate_o   (tstate_o),
  .phase_o    (phase_o),
  .lat_addr_o (lat_addr_o)
);

// File: tb/mux_bus_seq_tb.sv
module mux_bus_seq_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_i = 1'b0;
  logic [2:0]   req_sts_i = 3'b111;
  logic [W-1:0] req_addr_i = '0;
  logic [W-1:0] req_wdata_i = '0;
  logic         req_ack_o;
  logic         ready_i = 1'b0;
  logic [W-1:0] ad_i = '0;
  logic [W-1:0] ad_o;
  logic         ad_oe_o, ale_o, done_o, phase_o;
  logic [2:0]   sts_o, tstate_o, lat_sts_o;
  logic [W-1:0] rdata_o, lat_addr_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  mux_bus_seq #(.W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_sts_i(req_sts_i),
    .req_addr_i(req_addr_i), .req_wdata_i(req_wdata_i), .req_ack_o(req_ack_o),
    .ready_i(ready_i), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .ale_o(ale_o), .sts_o(sts_o), .done_o(done_o), .rdata_o(rdata_o),
    .tstate_o(tstate_o), .phase_o(phase_o), .lat_addr_o(lat_addr_o),
    .lat_sts_o(lat_sts_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_cycle(input logic [2:0] code, input logic [W-1:0] addr,
                           input logic [W-1:0] wdata, input logic [W-1:0] rdval,
                           input int waits, input bit chained);
    bit wr;
    wr = code[1] & ~code[0];
    req_i = 1'b1; req_sts_i = code; req_addr_i = addr; req_wdata_i = wdata;
    #1;
    chk("R3 ack in slot", int'(req_ack_o), 1);
    chk("R12 start state", int'(tstate_o), chained ? 5 : 0);
    @(negedge clk);
    req_i = 1'b0;
    chk("R4 ale announce", int'(ale_o), 1);
    chk("R4 sts announce", int'(sts_o), int'(code));
    chk("R2 phase 2", int'(phase_o), 1);
    @(negedge clk);
    chk("R6 T1", int'(tstate_o), 1);
    chk("R4 ale T1 ph1", int'(ale_o), 1);
    chk("R5 oe T1", int'(ad_oe_o), 1);
    chk("R5 addr T1 ph1", int'(ad_o), int'(addr));
    @(negedge clk);
    chk("R4 ale T1 ph2", int'(ale_o), 0);
    chk("R5 addr T1 ph2", int'(ad_o), int'(addr));
    chk("R11 lat addr", int'(lat_addr_o), int'(addr));
    chk("R11 lat sts", int'(lat_sts_o), int'(code));
    ad_i = rdval;
    @(negedge clk);
    chk("R6 T2", int'(tstate_o), 2);
    chk("R9 oe T2", int'(ad_oe_o), int'(wr));
    if (wr) chk("R9 wdata T2", int'(ad_o), int'(wdata));
    req_i = 1'b1;
    #1;
    chk("R3 no ack T2", int'(req_ack_o), 0);
    @(negedge clk);
    chk("R3 no ack T2 ph2", int'(req_ack_o), 0);
    chk("R4 ale low T2", int'(ale_o), 0);
    req_i = 1'b0;
    @(negedge clk);
    chk("R6 T3", int'(tstate_o), 3);
    chk("R8 sts T3 ph1", int'(sts_o), int'(code));
    ready_i = (waits == 0);
    @(negedge clk);
    chk("R8 sts T3 ph2", int'(sts_o), waits == 0 ? 7 : int'(code));
    for (int k = 0; k < waits; k++) begin
      @(negedge clk);
      chk("R7 TW", int'(tstate_o), 4);
      chk("R8 sts TW ph1", int'(sts_o), int'(code));
      ready_i = (k == waits - 1);
      @(negedge clk);
      chk("R8 sts TW ph2", int'(sts_o), (k == waits - 1) ? 7 : int'(code));
      chk("R9 oe TW", int'(ad_oe_o), int'(wr));
    end
    @(negedge clk);
    ready_i = 1'b0;
    ad_i = '0;
    chk("R7 T4", int'(tstate_o), 5);
    chk("R10 done", int'(done_o), 1);
    chk("R8 sts T4", int'(sts_o), 7);
    chk("R9 oe T4", int'(ad_oe_o), int'(wr));
    if (wr) chk("R9 wdata T4", int'(ad_o), int'(wdata));
    else    chk("R9 rdata", int'(rdata_o), int'(rdval));
    chk("R11 lat hold", int'(lat_addr_o), int'(addr));
  endtask

  initial begin
    #5;
    chk("R1 tstate", int'(tstate_o), 0);
    chk("R1 phase", int'(phase_o), 0);
    chk("R1 ale", int'(ale_o), 0);
    chk("R1 sts", int'(sts_o), 7);
    chk("R1 oe", int'(ad_oe_o), 0);
    chk("R1 done", int'(done_o), 0);
    chk("R1 ack", int'(req_ack_o), 0);
    @(negedge clk);
    @(negedge clk);
    rst_ni = 1'b1;
    // passive code is never taken
    req_i = 1'b1; req_sts_i = 3'b111;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R3 passive no ack", int'(req_ack_o), 0);
      chk("R3 passive stays TI", int'(tstate_o), 0);
      chk("R3 passive no ale", int'(ale_o), 0);
    end
    req_i = 1'b0;
    while (phase_o) @(negedge clk);
    for (int c = 0; c < 7; c++) begin
      for (int w = 0; w < 4; w++) begin
        logic [W-1:0] a;
        bit chain_next, prev_chain;
        a = W'(c * 37 + w * 5 + 1);
        prev_chain = (w % 2 == 0) && (w > 0);
        chain_next = (w % 2 == 1) && (w < 3);
        run_cycle(3'(c), a, ~a, a ^ 8'h5a, w, prev_chain);
        if (!chain_next) begin
          @(negedge clk);
          chk("R10 done low", int'(done_o), 0);
          chk("R4 no ale idle", int'(ale_o), 0);
          chk("R8 sts passive", int'(sts_o), 7);
          chk("R2 T4 ph2", int'(tstate_o), 5);
          @(negedge clk);
          chk("R6 idle after T4", int'(tstate_o), 0);
        end
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule